// File: doc/BRIEF.md
# Dual-Bank Select and Concurrency Arbiter

This block sits between a host-style asynchronous memory interface and two memory banks, a flash bank and an SRAM bank. The two banks share one address bus, one 8-bit data bus, one write strobe and one output gate. Each bank has its own active-low select. The block samples all strobes on a system clock through a two-flop synchronizer. It decides which bank each access belongs to, when the data bus is driven and when a flash write must be suppressed. It then hands each bank a request on a simple port, with the address and the data.

Flash takes priority. When both selects are low, the access goes to the flash bank and the SRAM select is ignored. Nothing on the flash side gates SRAM traffic. The SRAM can therefore be read and written while the flash bank runs an internal program or erase started by an earlier write request. Write strobes shorter than a minimum number of sampled cycles are treated as noise and never become requests.

Top module: `dual_bank_arbiter`

## Requirements
- R1: When both selects are low, the access is routed to the flash bank: reads return flash data, a write strobe produces a flash write request, and the SRAM receives no request.
- R2: When both selects are high, no bank request is issued, `bus_drive` is 0 and `standby` is 1. This is also the state after reset.
- R3: `bus_drive` is 1 only while a bank is selected, `rdgate_n` is low and `wstb_n` is high. It is 0 whenever `rdgate_n` is high or `wstb_n` is low.
- R4: An SRAM write takes place with `sram_sel_n` low, `flash_sel_n` high and `wstb_n` low. The block issues one `sr_wr` request carrying the address and data that were present in the last sampled cycle before the strobe or select rose. A later read returns that data.
- R5: A flash write strobe while `rdgate_n` is low produces no `fl_wr` request. With `rdgate_n` high, a flash write produces one `fl_wr` request with the captured address and data.
- R6: The SRAM receives address bits 16..0, so bit 17 is dropped. The flash receives all 18 address bits.
- R7: SRAM writes and reads complete normally right after a flash write request, while the flash bank may still be busy with it. No flash state gates the SRAM path.
- R8: A write strobe that is low for only one sampled cycle produces no request. A strobe that is low for 2 or more sampled cycles (GLITCH_MIN) produces one request.
- R9: Each qualified write strobe, however long it stays low, produces exactly one request pulse, and that pulse is one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flash_sel_n | input | 1 | Flash bank select, active low |
| sram_sel_n | input | 1 | SRAM bank select, active low |
| wstb_n | input | 1 | Shared write strobe, active low |
| rdgate_n | input | 1 | Shared output gate, active low |
| addr | input | 18 | Shared address |
| wdata | input | 8 | Shared write data |
| rdata_bus | output | 8 | Read data toward the host, 0 when not driven |
| bus_drive | output | 1 | High when the block drives `rdata_bus` |
| standby | output | 1 | High when neither bank is selected |
| fl_rd | output | 1 | Flash read request |
| fl_wr | output | 1 | Flash write request pulse |
| fl_addr | output | 18 | Flash request address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data return |
| sr_rd | output | 1 | SRAM read request |
| sr_wr | output | 1 | SRAM write request pulse |
| sr_addr | output | 17 | SRAM request address |
| sr_wdata | output | 8 | SRAM write data |
| sr_rdata | input | 8 | SRAM read data return |

## Verification
The bench goes after the cases where both selects are low. A design that let the SRAM select through would write SRAM data or return SRAM data on the bus instead of flash data. It drives one- and two-cycle strobes at the glitch threshold: a counter that is off by one either accepts noise or drops a legal write, and the readback then shows stale or corrupted data. It also drops the output gate during flash writes, where a missing inhibit shows up as an extra flash request. It uses bank addresses with bit 17 set, where a wrong SRAM address slice aliases into the wrong location. Random SRAM writes and reads interleaved with flash writes confirm that the SRAM path never stalls and never loses a write.

// File: rtl/dba_pkg.sv
// Package: shared types for the dual-bank arbiter.
// Assumes: one flash bank and one SRAM bank behind shared strobes.
package dba_pkg;

    // Bank targeted by the current sampled access.
    typedef enum logic [1:0] {
        BANK_NONE  = 2'd0,
        BANK_FLASH = 2'd1,
        BANK_SRAM  = 2'd2
    } bank_e;

    // Sampled control levels, all active low.
    typedef struct packed {
        logic flash_n;
        logic sram_n;
        logic strobe_n;
        logic gate_n;
    } ctl_t;

endpackage

// File: rtl/dba_sync.sv
// Module: dba_sync
// A multi-stage flop pipeline. It synchronizes the control strobes and keeps
// the address and data aligned with them.
// Assumes: each bit is sampled independently, and the reset value is per bit.
module dba_sync #(
    parameter int unsigned   W       = 4,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Capture the raw input into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d_i;
            end
        end else begin : g_next
            // Move the value one stage down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/dba_decode.sv
// Module: dba_decode
// Combinational decode of the synchronized controls. It picks the bank,
// detects a read, and forms the per-bank write levels and the flash inhibit.
// Assumes: inputs are already synchronized. Flash wins when both selects are low.
module dba_decode
    import dba_pkg::*;
(
    input  ctl_t  ctl_i,
    output bank_e bank_o,
    output logic  rd_o,
    output logic  fl_low_o,
    output logic  fl_inh_o,
    output logic  sr_low_o
);

    // Bank choice, with the flash select dominant.
    always_comb begin
        if (!ctl_i.flash_n)     bank_o = BANK_FLASH;
        else if (!ctl_i.sram_n) bank_o = BANK_SRAM;
        else                    bank_o = BANK_NONE;
    end

    // Read, write level and inhibit terms.
    always_comb begin
        rd_o     = (bank_o != BANK_NONE) && !ctl_i.gate_n && ctl_i.strobe_n;
        fl_low_o = (bank_o == BANK_FLASH) && !ctl_i.strobe_n;
        fl_inh_o = !ctl_i.gate_n;
        sr_low_o = (bank_o == BANK_SRAM) && !ctl_i.strobe_n;
    end

endmodule

// File: rtl/dba_wqual.sv
// Module: dba_wqual
// Write qualifier for one bank. It measures how long the write level stays
// low. When the level ends after at least MIN cycles, it issues one request
// pulse with the address and data captured in the last active cycle.
// Assumes: low_i and inhibit_i come from synchronized controls.
module dba_wqual #(
    parameter int unsigned AW  = 17,
    parameter int unsigned DW  = 8,
    parameter int unsigned MIN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          low_i,
    input  logic          inhibit_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);

    localparam int unsigned CW = $clog2(MIN + 1);

    logic          act_q;
    logic [CW-1:0] cnt_q;
    logic          req_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          live;

    assign live = low_i && !inhibit_i;

    // Track the active level, count its length and fire when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= act_q && !low_i && !inhibit_i && (cnt_q >= CW'(MIN));
            act_q <= live;
            if (!live)                cnt_q <= '0;
            else if (cnt_q < CW'(MIN)) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Hold the address and data of the most recent active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (live) begin
            addr_q <= addr_i;
            data_q <= data_i;
        end
    end

    assign req_o  = req_q;
    assign addr_o = addr_q;
    assign data_o = data_q;

    // R9: a request pulse never lasts more than one clock.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);

endmodule

// File: rtl/dual_bank_arbiter.sv
// Module: dual_bank_arbiter (top)
// Routes the accesses of a shared asynchronous memory interface to a flash
// bank or an SRAM bank. It synchronizes the strobes, gives flash priority,
// drives read data only during qualified reads, inhibits flash writes while
// the output gate is low, and filters short write strobes.
// Assumes: address and data are stable while a strobe is active and for a
// few cycles after it. The bank read data returns combinationally from the
// request address.
module dual_bank_arbiter
    import dba_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned SRAM_AW    = 17,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SYNC_STG   = 2,
    parameter int unsigned GLITCH_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flash_sel_n,
    input  logic              sram_sel_n,
    input  logic              wstb_n,
    input  logic              rdgate_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_bus,
    output logic              bus_drive,
    output logic              standby,
    output logic              fl_rd,
    output logic              fl_wr,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              sr_rd,
    output logic              sr_wr,
    output logic [SRAM_AW-1:0] sr_addr,
    output logic [DATA_W-1:0] sr_wdata,
    input  logic [DATA_W-1:0] sr_rdata
);

    localparam int unsigned CTL_W = $bits(ctl_t);
    localparam int unsigned BUS_W = ADDR_W + DATA_W;

    ctl_t              ctl_raw;
    logic [CTL_W-1:0]  ctl_q;
    ctl_t              ctl_s;
    logic [BUS_W-1:0]  bus_q;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;

    bank_e             bank;
    logic              rd;
    logic              fl_low, fl_inh, sr_low;

    logic              fl_rd_q, sr_rd_q, den_q, src_sram_q, stby_q;
    logic [ADDR_W-1:0] rd_addr_q;

    logic [ADDR_W-1:0]  wf_addr;
    logic [SRAM_AW-1:0] ws_addr;

    assign ctl_raw = '{flash_n: flash_sel_n, sram_n: sram_sel_n,
                       strobe_n: wstb_n, gate_n: rdgate_n};

    dba_sync #(.W(CTL_W), .STAGES(SYNC_STG), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ctl_raw), .q_o(ctl_q)
    );

    dba_sync #(.W(BUS_W), .STAGES(SYNC_STG), .RST_VAL({BUS_W{1'b0}})) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d_i({addr, wdata}), .q_o(bus_q)
    );

    assign ctl_s  = ctl_t'(ctl_q);
    assign addr_s = bus_q[BUS_W-1:DATA_W];
    assign data_s = bus_q[DATA_W-1:0];

    dba_decode u_dec (
        .ctl_i(ctl_s), .bank_o(bank), .rd_o(rd),
        .fl_low_o(fl_low), .fl_inh_o(fl_inh), .sr_low_o(sr_low)
    );

    dba_wqual #(.AW(ADDR_W), .DW(DATA_W), .MIN(GLITCH_MIN)) u_wq_flash (
        .clk(clk), .rst_n(rst_n), .low_i(fl_low), .inhibit_i(fl_inh),
        .addr_i(addr_s), .data_i(data_s),
        .req_o(fl_wr), .addr_o(wf_addr), .data_o(fl_wdata)
    );

    dba_wqual #(.AW(SRAM_AW), .DW(DATA_W), .MIN(GLITCH_MIN)) u_wq_sram (
        .clk(clk), .rst_n(rst_n), .low_i(sr_low), .inhibit_i(1'b0),
        .addr_i(addr_s[SRAM_AW-1:0]), .data_i(data_s),
        .req_o(sr_wr), .addr_o(ws_addr), .data_o(sr_wdata)
    );

    // Register the read requests, the bus drive and the standby state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_rd_q    <= 1'b0;
            sr_rd_q    <= 1'b0;
            den_q      <= 1'b0;
            src_sram_q <= 1'b0;
            stby_q     <= 1'b1;
            rd_addr_q  <= '0;
        end else begin
            fl_rd_q    <= rd && (bank == BANK_FLASH);
            sr_rd_q    <= rd && (bank == BANK_SRAM);
            den_q      <= rd;
            src_sram_q <= (bank == BANK_SRAM);
            stby_q     <= (bank == BANK_NONE);
            rd_addr_q  <= addr_s;
        end
    end

    assign fl_rd     = fl_rd_q;
    assign sr_rd     = sr_rd_q;
    assign fl_addr   = fl_wr ? wf_addr : rd_addr_q;
    assign sr_addr   = sr_wr ? ws_addr : rd_addr_q[SRAM_AW-1:0];
    assign bus_drive = den_q;
    assign standby   = stby_q;
    assign rdata_bus = !den_q ? '0 : (src_sram_q ? sr_rdata : fl_rdata);

    // R1: a low flash select keeps SRAM reads off in the next cycle.
    a_r1_flash_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_s.flash_n |=> !sr_rd);

    // R2: in standby, nothing is requested and the bus floats.
    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!bus_drive && !fl_rd && !sr_rd));

    // R3: a high output gate floats the bus in the next cycle.
    a_r3_gate_floats: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_s.gate_n |=> !bus_drive);

    // R3: at most one bank is read at a time.
    a_r3_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_rd, sr_rd}));

    // R5: a low output gate suppresses a flash write request in the next cycle.
    a_r5_flash_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_s.gate_n |=> !fl_wr);

endmodule

// File: tb/dual_bank_arbiter_test.sv
// Bench for dual_bank_arbiter: directed corner cases plus seeded random
// SRAM traffic, checked against expected values computed in the bench.
module dual_bank_arbiter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flash_sel_n = 1'b1, sram_sel_n = 1'b1, wstb_n = 1'b1, rdgate_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata_bus;
    logic        bus_drive, standby;
    logic        fl_rd, fl_wr, sr_rd, sr_wr;
    logic [17:0] fl_addr;
    logic [16:0] sr_addr;
    logic [7:0]  fl_wdata, sr_wdata, fl_rdata, sr_rdata;

    logic [7:0]  mem [256];
    logic [7:0]  exp_mem [256];
    int          n_srwr = 0, n_flwr = 0, n_srrd = 0;
    logic [16:0] last_sr_addr = '0;
    logic [7:0]  last_sr_data = '0;
    logic [17:0] last_fl_addr = '0;
    logic [7:0]  last_fl_data = '0;
    int          checks = 0, errors = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] fl_fn(input logic [17:0] a);
        return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'h3C;
    endfunction

    assign fl_rdata = fl_fn(fl_addr);
    assign sr_rdata = mem[sr_addr[7:0]];

    dual_bank_arbiter uut (
        .clk(clk), .rst_n(rst_n), .flash_sel_n(flash_sel_n), .sram_sel_n(sram_sel_n),
        .wstb_n(wstb_n), .rdgate_n(rdgate_n), .addr(addr), .wdata(wdata),
        .rdata_bus(rdata_bus), .bus_drive(bus_drive), .standby(standby),
        .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .sr_rd(sr_rd), .sr_wr(sr_wr), .sr_addr(sr_addr),
        .sr_wdata(sr_wdata), .sr_rdata(sr_rdata)
    );

    // Bank models and request counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sr_wr) begin
                mem[sr_addr[7:0]] = sr_wdata;
                n_srwr++;
                last_sr_addr = sr_addr;
                last_sr_data = sr_wdata;
            end
            if (fl_wr) begin
                n_flwr++;
                last_fl_addr = fl_addr;
                last_fl_data = fl_wdata;
            end
            if (sr_rd) n_srrd++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        flash_sel_n = 1'b1; sram_sel_n = 1'b1; wstb_n = 1'b1; rdgate_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic fs, input logic ss, input logic [17:0] a,
                            input logic [7:0] d, input int len, input logic gate);
        @(negedge clk);
        addr = a; wdata = d; flash_sel_n = fs; sram_sel_n = ss; rdgate_n = gate;
        wstb_n = 1'b1;
        @(negedge clk);
        wstb_n = 1'b0;
        repeat (len) @(negedge clk);
        wstb_n = 1'b1;
        repeat (4) @(negedge clk);
        idle(3);
    endtask

    task automatic do_read(input logic fs, input logic ss, input logic [17:0] a,
                           output logic [7:0] d, output logic drv);
        @(negedge clk);
        addr = a; flash_sel_n = fs; sram_sel_n = ss; wstb_n = 1'b1; rdgate_n = 1'b0;
        repeat (4) @(negedge clk);
        d = rdata_bus; drv = bus_drive;
        idle(3);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hang expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       drv;
        int         s0, f0, r0;
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2: reset and idle state.
        chk("R2 reset bus_drive", bus_drive, 0);
        chk("R2 reset standby", standby, 1);
        chk("R2 reset no requests", {fl_rd, fl_wr, sr_rd, sr_wr}, 0);

        // R4 / R6: SRAM write with bit 17 set, then readback.
        s0 = n_srwr;
        do_write(1'b1, 1'b0, 18'h3_0012, 8'hA5, 3, 1'b1);
        exp_mem[8'h12] = 8'hA5;
        chk("R4 one sram write", n_srwr - s0, 1);
        chk("R6 sram addr drops bit17", last_sr_addr, 17'h1_0012);
        chk("R4 sram data", last_sr_data, 8'hA5);
        do_read(1'b1, 1'b0, 18'h1_0012, d, drv);
        chk("R4 sram readback", d, 8'hA5);
        chk("R3 read drives bus", drv, 1);

        // R6 / R3: flash read with full address.
        do_read(1'b0, 1'b1, 18'h2_ABCD, d, drv);
        chk("R6 flash read data", d, fl_fn(18'h2_ABCD));

        // R1: both selects low, read and write go to flash.
        r0 = n_srrd;
        do_read(1'b0, 1'b0, 18'h0_0012, d, drv);
        chk("R1 both-low read is flash", d, fl_fn(18'h0_0012));
        chk("R1 no sram read", n_srrd - r0, 0);
        s0 = n_srwr; f0 = n_flwr;
        do_write(1'b0, 1'b0, 18'h0_0012, 8'h77, 3, 1'b1);
        chk("R1 flash write issued", n_flwr - f0, 1);
        chk("R1 no sram write", n_srwr - s0, 0);
        do_read(1'b1, 1'b0, 18'h0_0012, d, drv);
        chk("R1 sram untouched", d, 8'hA5);

        // R3: gate high or strobe low leaves the bus floating.
        @(negedge clk);
        flash_sel_n = 1'b1; sram_sel_n = 1'b0; rdgate_n = 1'b1; wstb_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 gate high floats", bus_drive, 0);
        rdgate_n = 1'b0; wstb_n = 1'b0; addr = 18'h0_0040; wdata = 8'h40;
        repeat (4) @(negedge clk);
        chk("R3 strobe low floats", bus_drive, 0);
        wstb_n = 1'b1; rdgate_n = 1'b1;
        repeat (4) @(negedge clk);
        exp_mem[8'h40] = 8'h40;
        idle(3);

        // R5: flash write blocked by a low gate, accepted with a high gate.
        f0 = n_flwr;
        do_write(1'b0, 1'b1, 18'h1_2345, 8'h5C, 3, 1'b0);
        chk("R5 inhibited flash write", n_flwr - f0, 0);
        do_write(1'b0, 1'b1, 18'h1_2345, 8'h5C, 3, 1'b1);
        chk("R5 flash write accepted", n_flwr - f0, 1);
        chk("R5 flash write addr", last_fl_addr, 18'h1_2345);
        chk("R5 flash write data", last_fl_data, 8'h5C);

        // R7: SRAM traffic right after a flash write request.
        s0 = n_srwr;
        do_write(1'b1, 1'b0, 18'h0_0033, 8'hC7, 2, 1'b1);
        exp_mem[8'h33] = 8'hC7;
        chk("R7 sram write after flash", n_srwr - s0, 1);
        do_read(1'b1, 1'b0, 18'h0_0033, d, drv);
        chk("R7 sram read after flash", d, 8'hC7);

        // R8: one-cycle strobe is noise, two-cycle strobe is a write.
        s0 = n_srwr;
        do_write(1'b1, 1'b0, 18'h0_0012, 8'h11, 1, 1'b1);
        chk("R8 glitch ignored", n_srwr - s0, 0);
        do_read(1'b1, 1'b0, 18'h0_0012, d, drv);
        chk("R8 glitch left data", d, 8'hA5);
        do_write(1'b1, 1'b0, 18'h0_0012, 8'h22, 2, 1'b1);
        exp_mem[8'h12] = 8'h22;
        chk("R8 minimum strobe accepted", n_srwr - s0, 1);

        // R9: a long strobe yields exactly one request.
        s0 = n_srwr;
        do_write(1'b1, 1'b0, 18'h0_0099, 8'h99, 9, 1'b1);
        exp_mem[8'h99] = 8'h99;
        chk("R9 one request per strobe", n_srwr - s0, 1);

        // R4 / R7: seeded random SRAM writes interleaved with flash writes.
        for (int i = 0; i < 40; i++) begin
            logic [17:0] ra;
            logic [7:0]  rdv;
            int          ln;
            ra  = 18'($urandom);
            rdv = 8'($urandom);
            ln  = 2 + int'($urandom % 4);
            if (($urandom % 4) == 0)
                do_write(1'b0, 1'b1, ra, rdv, ln, 1'b1);
            else begin
                do_write(1'b1, 1'b0, ra, rdv, ln, 1'b1);
                exp_mem[ra[7:0]] = rdv;
            end
        end
        for (int i = 0; i < 30; i++) begin
            logic [17:0] ra;
            ra = 18'($urandom);
            if (i % 3 == 0) begin
                do_read(1'b0, 1'b1, ra, d, drv);
                chk("R6 random flash read", d, fl_fn(ra));
            end else begin
                do_read(1'b1, 1'b0, ra, d, drv);
                chk("R4 random sram read", d, exp_mem[ra[7:0]]);
            end
        end

        // R2: back to standby.
        idle(4);
        chk("R2 final standby", standby, 1);
        chk("R2 final bus float", bus_drive, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule